// File: doc/BRIEF.md
# Eight-Lane Sub-Pixel Interpolation Scheduler

This block sequences a bank of eight parallel interpolation lanes through every fractional position of one 8x8 luma block. Each lane holds three filter variants (call them types A, B and C). The scheduler does no arithmetic and holds no pixel data. Each cycle it tells the surrounding datapath four things: which rows of the integer window or of the filtered-pixel buffers to read, in which direction the taps run, which buffers to write, and which group of results the output buffer should latch.

A block runs in four steps. First the padded integer window is captured in a single cycle. Next come the vertically filtered half positions: eight output rows, one row per cycle, with all three filters active. Then the horizontally filtered half positions run over 15 padded rows and fill three filtered-pixel buffers at once. The block needs 15 rows here because later vertical filtering needs seven rows of margin around the eight block rows. Last, the quarter positions take 24 cycles: eight output rows for each of the three filtered buffers in turn. A one-cycle completion pulse follows. With no stall, one block takes 48 working cycles.

A stall input freezes progress without losing position. A start request is taken only when the block is idle and the upstream data is marked ready.

Top module: `fis_sched`

## Requirements
- R1: After reset the block is idle: busy, done and every enable are low, and every row, select and group output is zero.
- R2: A start is taken when start_i and blk_ready_i are both high while the block is idle. In the next cycle win_load_o is high for exactly one working cycle.
- R3: The vertical half phase lasts 8 working cycles. In each one int_rd_en_o=1, tap_dir_o=1 and int_rd_row_o counts 0..7. The output buffer is written with obuf_grp_o=0 and obuf_row_o equal to the same row.
- R4: The horizontal half phase lasts 15 working cycles. In each one int_rd_en_o=1, tap_dir_o=0 and int_rd_row_o counts 0..14. All three filtered-buffer write strobes (fbuf_wr_en_o=3'b111) are high, with fbuf_wr_row_o equal to the same row.
- R5: The quarter phase lasts 24 working cycles. fbuf_rd_sel_o is 0, 1 and 2 (first, second and third filtered buffer) for 8 cycles each. Within each group fbuf_rd_row_o counts 0..7. The output buffer is written with obuf_grp_o = fbuf_rd_sel_o+1 and obuf_row_o equal to the read row.
- R6: After the 48th working cycle, done_o is high for exactly one cycle and the block then returns to idle. With no stall, the done cycle comes 48 cycles after the load cycle.
- R7: While stall_i is high, every enable and write strobe is low. No position is lost: the sequence resumes at the step where it stopped.
- R8: A start request while the block is busy, including the done cycle, is ignored.
- R9: A start request while blk_ready_i is low is ignored.
- R10: Any row, select or group output that does not belong to the current phase is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to process one block |
| blk_ready_i | input | 1 | Integer window for the next block is available |
| stall_i | input | 1 | Freeze progress this cycle |
| busy_o | output | 1 | A block is in progress |
| win_load_o | output | 1 | Capture the padded integer window |
| int_rd_en_o | output | 1 | Lanes read the integer window |
| tap_dir_o | output | 1 | 1 = vertical taps, 0 = horizontal taps |
| int_rd_row_o | output | 4 | Integer window row (top of tap window when vertical) |
| fbuf_wr_en_o | output | 3 | Write strobes of the three filtered-pixel buffers |
| fbuf_wr_row_o | output | 4 | Filtered-buffer write row |
| fbuf_rd_en_o | output | 1 | Lanes read a filtered-pixel buffer |
| fbuf_rd_sel_o | output | 2 | Filtered buffer being read (0..2) |
| fbuf_rd_row_o | output | 3 | Top row of the vertical tap window in that buffer |
| obuf_wr_en_o | output | 1 | Output buffer write strobe |
| obuf_grp_o | output | 2 | Result group: 0 vertical halves, 1..3 quarters from buffer 0..2 |
| obuf_row_o | output | 3 | Output row written |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a stall that lands exactly on a phase boundary or on the done cycle. A missed hold there would skip or repeat a row at a change of source buffer. The bench runs whole blocks under random stall densities up to 60 percent, so stalls land on every step of the 48 across runs. The scoreboard compares only the working cycles against the expected sequence, which does not depend on stall timing. The same runs inject start pulses while busy to show that they never create extra items.

// File: rtl/fis_pkg.sv
package fis_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LOAD  = 3'd1,
    PH_VERT  = 3'd2,
    PH_HORZ  = 3'd3,
    PH_QUART = 3'd4,
    PH_DONE  = 3'd5
  } phase_e;
endpackage

// File: rtl/fis_rst_sync.sv
module fis_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/fis_phase_fsm.sv
module fis_phase_fsm
  import fis_pkg::*;
#(
  parameter int N     = 8,
  parameter int HROWS = 15,
  parameter int NSRC  = 3,
  parameter int ROW_W = 4,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             blk_ready_i,
  input  logic             stall_i,
  output phase_e           phase_o,
  output logic [ROW_W-1:0] row_o,
  output logic [SRC_W-1:0] src_o
);
  localparam logic [ROW_W-1:0] LAST_B = ROW_W'(N - 1);
  localparam logic [ROW_W-1:0] LAST_H = ROW_W'(HROWS - 1);
  localparam logic [SRC_W-1:0] LAST_S = SRC_W'(NSRC - 1);

  phase_e           phase_q, phase_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [SRC_W-1:0] src_q, src_d;
  logic             adv;

  assign adv = !stall_i;

  always_comb begin
    phase_d = phase_q;
    row_d   = row_q;
    src_d   = src_q;
    case (phase_q)
      PH_IDLE: begin
        row_d = '0;
        src_d = '0;
        if (start_i && blk_ready_i) phase_d = PH_LOAD;
      end
      PH_LOAD: begin
        if (adv) phase_d = PH_VERT;
      end
      PH_VERT: begin
        if (adv) begin
          if (row_q == LAST_B) begin
            phase_d = PH_HORZ;
            row_d   = '0;
          end else begin
            row_d = row_q + 1'b1;
          end
        end
      end
      PH_HORZ: begin
        if (adv) begin
          if (row_q == LAST_H) begin
            phase_d = PH_QUART;
            row_d   = '0;
            src_d   = '0;
          end else begin
            row_d = row_q + 1'b1;
          end
        end
      end
      PH_QUART: begin
        if (adv) begin
          if (row_q == LAST_B) begin
            row_d = '0;
            if (src_q == LAST_S) phase_d = PH_DONE;
            else                 src_d   = src_q + 1'b1;
          end else begin
            row_d = row_q + 1'b1;
          end
        end
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      src_q   <= '0;
    end else begin
      phase_q <= phase_d;
      row_q   <= row_d;
      src_q   <= src_d;
    end
  end

  assign phase_o = phase_q;
  assign row_o   = row_q;
  assign src_o   = src_q;
endmodule

// File: rtl/fis_strobe_dec.sv
module fis_strobe_dec
  import fis_pkg::*;
#(
  parameter int NSRC   = 3,
  parameter int ROW_W  = 4,
  parameter int SRC_W  = 2,
  parameter int OROW_W = 3,
  parameter int GRP_W  = 2
) (
  input  phase_e            phase_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              stall_i,
  output logic              busy_o,
  output logic              win_load_o,
  output logic              int_rd_en_o,
  output logic              tap_dir_o,
  output logic [ROW_W-1:0]  int_rd_row_o,
  output logic [NSRC-1:0]   fbuf_wr_en_o,
  output logic [ROW_W-1:0]  fbuf_wr_row_o,
  output logic              fbuf_rd_en_o,
  output logic [SRC_W-1:0]  fbuf_rd_sel_o,
  output logic [OROW_W-1:0] fbuf_rd_row_o,
  output logic              obuf_wr_en_o,
  output logic [GRP_W-1:0]  obuf_grp_o,
  output logic [OROW_W-1:0] obuf_row_o,
  output logic              done_o
);
  logic is_vert, is_horz, is_quart, go;

  assign is_vert  = (phase_i == PH_VERT);
  assign is_horz  = (phase_i == PH_HORZ);
  assign is_quart = (phase_i == PH_QUART);
  assign go       = !stall_i;

  assign busy_o       = (phase_i != PH_IDLE);
  assign done_o       = (phase_i == PH_DONE);
  assign win_load_o   = (phase_i == PH_LOAD) && go;
  assign int_rd_en_o  = (is_vert || is_horz) && go;
  assign tap_dir_o    = is_vert;
  assign int_rd_row_o = (is_vert || is_horz) ? row_i : '0;

  for (genvar g = 0; g < NSRC; g++) begin : g_fbuf_we
    assign fbuf_wr_en_o[g] = is_horz && go;
  end
  assign fbuf_wr_row_o = is_horz ? row_i : '0;

  assign fbuf_rd_en_o  = is_quart && go;
  assign fbuf_rd_sel_o = is_quart ? src_i : '0;
  assign fbuf_rd_row_o = is_quart ? row_i[OROW_W-1:0] : '0;

  assign obuf_wr_en_o = (is_vert || is_quart) && go;
  assign obuf_grp_o   = is_quart ? (GRP_W'(src_i) + GRP_W'(1)) : '0;
  assign obuf_row_o   = (is_vert || is_quart) ? row_i[OROW_W-1:0] : '0;
endmodule

// File: rtl/fis_sched.sv
module fis_sched
  import fis_pkg::*;
#(
  parameter int N    = 8,
  parameter int TAPS = 8,
  parameter int NSRC = 3,
  localparam int HROWS  = N + TAPS - 1,
  localparam int ROW_W  = $clog2(HROWS),
  localparam int OROW_W = $clog2(N),
  localparam int SRC_W  = $clog2(NSRC),
  localparam int GRP_W  = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              blk_ready_i,
  input  logic              stall_i,
  output logic              busy_o,
  output logic              win_load_o,
  output logic              int_rd_en_o,
  output logic              tap_dir_o,
  output logic [ROW_W-1:0]  int_rd_row_o,
  output logic [NSRC-1:0]   fbuf_wr_en_o,
  output logic [ROW_W-1:0]  fbuf_wr_row_o,
  output logic              fbuf_rd_en_o,
  output logic [SRC_W-1:0]  fbuf_rd_sel_o,
  output logic [OROW_W-1:0] fbuf_rd_row_o,
  output logic              obuf_wr_en_o,
  output logic [GRP_W-1:0]  obuf_grp_o,
  output logic [OROW_W-1:0] obuf_row_o,
  output logic              done_o
);
  logic             rst_sync_n;
  phase_e           phase;
  logic [ROW_W-1:0] row;
  logic [SRC_W-1:0] src;

  fis_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fis_phase_fsm #(
    .N(N), .HROWS(HROWS), .NSRC(NSRC), .ROW_W(ROW_W), .SRC_W(SRC_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .blk_ready_i (blk_ready_i),
    .stall_i     (stall_i),
    .phase_o     (phase),
    .row_o       (row),
    .src_o       (src)
  );

  fis_strobe_dec #(
    .NSRC(NSRC), .ROW_W(ROW_W), .SRC_W(SRC_W), .OROW_W(OROW_W), .GRP_W(GRP_W)
  ) u_dec (
    .phase_i       (phase),
    .row_i         (row),
    .src_i         (src),
    .stall_i       (stall_i),
    .busy_o        (busy_o),
    .win_load_o    (win_load_o),
    .int_rd_en_o   (int_rd_en_o),
    .tap_dir_o     (tap_dir_o),
    .int_rd_row_o  (int_rd_row_o),
    .fbuf_wr_en_o  (fbuf_wr_en_o),
    .fbuf_wr_row_o (fbuf_wr_row_o),
    .fbuf_rd_en_o  (fbuf_rd_en_o),
    .fbuf_rd_sel_o (fbuf_rd_sel_o),
    .fbuf_rd_row_o (fbuf_rd_row_o),
    .obuf_wr_en_o  (obuf_wr_en_o),
    .obuf_grp_o    (obuf_grp_o),
    .obuf_row_o    (obuf_row_o),
    .done_o        (done_o)
  );
endmodule

// File: rtl/fis_sched_chk.sv
module fis_sched_chk #(
  parameter int N      = 8,
  parameter int HROWS  = 15,
  parameter int NSRC   = 3,
  parameter int ROW_W  = 4,
  parameter int SRC_W  = 2,
  parameter int OROW_W = 3,
  parameter int GRP_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall_i,
  input logic              busy_o,
  input logic              win_load_o,
  input logic              int_rd_en_o,
  input logic [ROW_W-1:0]  int_rd_row_o,
  input logic [NSRC-1:0]   fbuf_wr_en_o,
  input logic              fbuf_rd_en_o,
  input logic [SRC_W-1:0]  fbuf_rd_sel_o,
  input logic [OROW_W-1:0] fbuf_rd_row_o,
  input logic              obuf_wr_en_o,
  input logic [GRP_W-1:0]  obuf_grp_o,
  input logic [OROW_W-1:0] obuf_row_o,
  input logic              done_o
);
  localparam int TOTAL = 1 + N + HROWS + NSRC * N;
  localparam int CNT_W = $clog2(TOTAL + 2);

  logic [CNT_W-1:0] work_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          work_q <= '0;
    else if (win_load_o)                 work_q <= CNT_W'(1);
    else if (int_rd_en_o || fbuf_rd_en_o) work_q <= work_q + 1'b1;
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  p_total_cycles_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (work_q == CNT_W'(TOTAL)));

  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !(win_load_o || int_rd_en_o || fbuf_rd_en_o || obuf_wr_en_o || (|fbuf_wr_en_o)));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && busy_o && !done_o) |=>
      ($stable(int_rd_row_o) && $stable(fbuf_rd_sel_o) && $stable(fbuf_rd_row_o) && $stable(obuf_row_o)));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_load_o, int_rd_en_o, fbuf_rd_en_o, done_o}));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  p_quarter_grp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fbuf_rd_en_o |-> (obuf_wr_en_o && (obuf_grp_o == GRP_W'(fbuf_rd_sel_o) + GRP_W'(1))));
endmodule

bind fis_sched fis_sched_chk #(
  .N(N), .HROWS(HROWS), .NSRC(NSRC), .ROW_W(ROW_W), .SRC_W(SRC_W),
  .OROW_W(OROW_W), .GRP_W(GRP_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stall_i       (stall_i),
  .busy_o        (busy_o),
  .win_load_o    (win_load_o),
  .int_rd_en_o   (int_rd_en_o),
  .int_rd_row_o  (int_rd_row_o),
  .fbuf_wr_en_o  (fbuf_wr_en_o),
  .fbuf_rd_en_o  (fbuf_rd_en_o),
  .fbuf_rd_sel_o (fbuf_rd_sel_o),
  .fbuf_rd_row_o (fbuf_rd_row_o),
  .obuf_wr_en_o  (obuf_wr_en_o),
  .obuf_grp_o    (obuf_grp_o),
  .obuf_row_o    (obuf_row_o),
  .done_o        (done_o)
);

// File: tb/test_fis_sched.sv
module test_fis_sched;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, blk_ready_i, stall_i;
  logic       busy_o, win_load_o, int_rd_en_o, tap_dir_o;
  logic [3:0] int_rd_row_o, fbuf_wr_row_o;
  logic [2:0] fbuf_wr_en_o, fbuf_rd_row_o, obuf_row_o;
  logic       fbuf_rd_en_o, obuf_wr_en_o, done_o;
  logic [1:0] fbuf_rd_sel_o, obuf_grp_o;

  always #4 clk = ~clk;

  fis_sched i_fis_sched (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_ready_i(blk_ready_i),
    .stall_i(stall_i), .busy_o(busy_o), .win_load_o(win_load_o),
    .int_rd_en_o(int_rd_en_o), .tap_dir_o(tap_dir_o), .int_rd_row_o(int_rd_row_o),
    .fbuf_wr_en_o(fbuf_wr_en_o), .fbuf_wr_row_o(fbuf_wr_row_o),
    .fbuf_rd_en_o(fbuf_rd_en_o), .fbuf_rd_sel_o(fbuf_rd_sel_o),
    .fbuf_rd_row_o(fbuf_rd_row_o), .obuf_wr_en_o(obuf_wr_en_o),
    .obuf_grp_o(obuf_grp_o), .obuf_row_o(obuf_row_o), .done_o(done_o)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, win_cyc = 0, done_cyc = 0, done_cnt = 0;
  logic [26:0] exp_q[$];

  function automatic logic [26:0] mk(bit wl, bit ie, bit td, int ir, bit [2:0] fw,
      int fwr, bit fre, int fs, int frr, bit ow, int og, int orow, bit dn);
    return {wl, ie, td, 4'(ir), fw, 4'(fwr), fre, 2'(fs), 3'(frr), ow, 2'(og), 3'(orow), dn};
  endfunction

  function automatic logic [26:0] actual();
    return {win_load_o, int_rd_en_o, tap_dir_o, int_rd_row_o, fbuf_wr_en_o, fbuf_wr_row_o,
            fbuf_rd_en_o, fbuf_rd_sel_o, fbuf_rd_row_o, obuf_wr_en_o, obuf_grp_o,
            obuf_row_o, done_o};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Driver side: expected working-cycle sequence of one block
  task automatic push_block();
    exp_q.push_back(mk(1,0,0,0,3'b000,0,0,0,0,0,0,0,0));               // R2 load
    for (int r = 0; r < 8; r++)                                        // R3
      exp_q.push_back(mk(0,1,1,r,3'b000,0,0,0,0,1,0,r,0));
    for (int r = 0; r < 15; r++)                                       // R4
      exp_q.push_back(mk(0,1,0,r,3'b111,r,0,0,0,0,0,0,0));
    for (int s = 0; s < 3; s++)                                        // R5
      for (int r = 0; r < 8; r++)
        exp_q.push_back(mk(0,0,0,0,3'b000,0,1,s,r,1,s+1,r,0));
    exp_q.push_back(mk(0,0,0,0,3'b000,0,0,0,0,0,0,0,1));               // R6 done
  endtask

  // Monitor side
  always @(negedge clk) begin
    if (rst_n) begin
      logic [26:0] a, e;
      string tag;
      cyc++;
      a = actual();
      if (stall_i)
        chk("R7 stall quiet", 32'({win_load_o, int_rd_en_o, fbuf_wr_en_o, fbuf_rd_en_o, obuf_wr_en_o}), 32'd0);
      if (win_load_o || int_rd_en_o || fbuf_rd_en_o || obuf_wr_en_o || (|fbuf_wr_en_o) || done_o) begin
        if (exp_q.size() == 0) begin
          chk("R8/R9 unexpected activity", 32'(a), 32'd0);
        end else begin
          e = exp_q.pop_front();
          if (e[0])        tag = "R6 done";
          else if (e[26])  tag = "R2 load";
          else if (e[24])  tag = "R3 vertical half";
          else if (e[25])  tag = "R4 horizontal half";
          else             tag = "R5 quarter";
          chk(tag, 32'(a), 32'(e));
        end
        if (win_load_o) win_cyc = cyc;
        if (done_o) begin
          done_cyc = cyc;
          done_cnt++;
        end
      end
    end
  end

  task automatic run_block(int pct, bit poke);
    int k;
    k = done_cnt;
    push_block();
    @(posedge clk); #1 start_i = 1'b1; blk_ready_i = 1'b1; stall_i = 1'b0;
    @(posedge clk); #1 start_i = 1'b0;
    while (done_cnt == k) begin
      stall_i = ($urandom_range(99) < pct);
      start_i = poke && ($urandom_range(5) == 0);   // R8 start while busy
      if (poke) blk_ready_i = $urandom_range(1);
      @(posedge clk); #1;
    end
    start_i = 1'b0; stall_i = 1'b0; blk_ready_i = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; blk_ready_i = 1'b0; stall_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", 32'(actual()), 32'd0);
    chk("R1 reset busy", 32'(busy_o), 32'd0);
    chk("R10 idle rows zero", 32'({int_rd_row_o, fbuf_rd_sel_o, obuf_grp_o}), 32'd0);

    // R9: start without ready
    @(posedge clk); #1 start_i = 1'b1; blk_ready_i = 1'b0;
    @(posedge clk); #1 start_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 start without ready", 32'(busy_o), 32'd0);

    // Plain block, latency check
    run_block(0, 1'b0);
    chk("R6 load-to-done cycles", 32'(done_cyc - win_cyc), 32'd48);
    @(negedge clk);
    chk("R6 idle after done", 32'(busy_o), 32'd0);

    // Stalled blocks with start pokes
    run_block(30, 1'b1);
    @(negedge clk);
    chk("R8 idle after poked block", 32'(busy_o), 32'd0);
    run_block(60, 1'b1);
    run_block(10, 1'b0);
    repeat (6) @(negedge clk);
    chk("R8 no extra block started", 32'(busy_o), 32'd0);
    chk("R6 all expected items consumed", 32'(exp_q.size()), 32'd0);
    chk("R6 block count", 32'(done_cnt), 32'd4);
    summary();
  end
endmodule